// File: doc/BRIEF.md
# Gate Drive Settle Timeout Monitor

This block sits between the commutation logic and the six gate drivers of a three-phase bridge. There is one high-side gate and one low-side gate per phase. The commutation logic supplies six commanded gate levels. An analog front end returns six comparator flags that show the level each gate has actually reached.

Every time a commanded level changes, the block starts a per-gate countdown of a programmable number of clock cycles. If the sensed flag has not followed the command by the end of that window, the block records a gate-drive fault. On a fault it drops all six drive outputs to the off level, pulls the active-low fault pin down, and latches a summary bit, a gate-drive-fault bit and one status bit per failing gate.

Recovery needs two things: every sensed flag must agree with the forced-off outputs, and an explicit clear must arrive. The clear can be a write strobe to a self-clearing clear bit, or a short low pulse on the enable pin. A low period on the enable pin longer than the pulse limit puts the block to sleep. In sleep all status is cleared and the outputs are held off. A disable input suppresses fault detection entirely.

Top module: `gdrv_timeout_mon`

## Requirements
- R1: Let E be the clock edge that registers a change of the effective command of gate i. If sense_gate[i] differs from that command in each of the win_len+1 cycles after E, the fault latches at edge E+win_len+1. A match in any of those cycles, including the last one, prevents the fault.
- R2: While no fault is latched and the block is awake, drv_out equals cmd_gate. While a fault is latched, drv_out is all zero.
- R3: A latched fault holds fault_n low, with st_fault and st_gdf both 1. Otherwise fault_n is 1 and both bits are 0.
- R4: The st_gate bit of every gate that timed out is set. The bit order is index 0 high-side A, 1 low-side A, 2 high-side B, 3 low-side B, 4 high-side C, 5 low-side C, and cmd_gate, sense_gate and drv_out use the same order. The bits hold until a clear or sleep.
- R5: A clear is carried out only when sense_gate equals the forced-off outputs, which is all zero. Otherwise the clear is ignored and fault_n and st_gate keep their values.
- R6: A clr_wr strobe sampled at edge E sets an internal clear bit, and that bit drops by itself one cycle later. The fault releases at edge E+1.
- R7: Let the enable pin be sampled low at N consecutive edges and then sampled high. If RST_MIN <= N <= RST_MAX, the fault clears at the edge where the pin is first sampled high. If N < RST_MIN, nothing changes.
- R8: Once en_pin has been sampled low at more than RST_MAX consecutive edges, the block sleeps. In sleep drv_out is zero, all status bits are zero and fault_n is 1. After the pin returns high the outputs follow cmd_gate again without any fault.
- R9: While det_dis is 1, no fault is raised, however long a gate stays mismatched.
- R10: While a fault is latched, changes of cmd_gate start no timeout and set no further st_gate bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_gate | input | 6 | Commanded gate levels |
| sense_gate | input | 6 | Sensed gate levels from comparators |
| win_len | input | WIN_W | Drive window length in cycles |
| det_dis | input | 1 | Disables fault detection |
| clr_wr | input | 1 | Write strobe of the clear-faults bit |
| en_pin | input | 1 | Enable pin (pulse clear or sleep) |
| drv_out | output | 6 | Gated drive outputs |
| fault_n | output | 1 | Active-low fault pin |
| st_fault | output | 1 | Latched summary fault bit |
| st_gdf | output | 1 | Latched gate-drive-fault bit |
| st_gate | output | 6 | Latched per-gate fault bits |

## Verification
A commanded edge is loaded into a timer at the next clock edge, so a stuck gate shows its fault after win_len+2 edges. The bench checks fault_n at win_len+1 edges and again at win_len+2 edges, and also checks a match that arrives in the final window cycle. A clr_wr strobe releases the fault after two edges, an accepted enable pulse after one edge past the rise, and sleep begins after RST_MAX+1 low edges. The bench samples one edge before and one edge after each of these points. All inputs change and all outputs are read at the falling clock edge, so every check lands on a known count of rising edges.

// File: rtl/gdm_pkg.sv
package gdm_pkg;
  localparam int GATE_COUNT = 6;

  typedef enum logic [2:0] {
    G_HA = 3'd0,
    G_LA = 3'd1,
    G_HB = 3'd2,
    G_LB = 3'd3,
    G_HC = 3'd4,
    G_LC = 3'd5
  } gate_idx_e;
endpackage

// File: rtl/gdm_gate_timer.sv
module gdm_gate_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eff_cmd,
  input  logic             sense,
  input  logic [WIN_W-1:0] win_len,
  input  logic             hold,
  output logic             tmo
);
  logic             cmd_q, act_q, act_d;
  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    tmo    = 1'b0;
    if (hold) begin
      act_d = 1'b0;
    end else if (eff_cmd != cmd_q) begin
      act_d  = 1'b1;
      cnt_d  = win_len;
      cnt_en = 1'b1;
    end else if (act_q) begin
      if (sense == cmd_q) begin
        act_d = 1'b0;
      end else if (cnt_q == '0) begin
        tmo   = 1'b1;
        act_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      cmd_q <= eff_cmd;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/gdm_en_filter.sv
module gdm_en_filter #(
  parameter int RST_MIN = 4,
  parameter int RST_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  output logic rst_pulse,
  output logic sleep
);
  localparam int          LO_W = $clog2(RST_MAX + 2);
  localparam logic [LO_W-1:0] SAT  = LO_W'(RST_MAX + 1);
  localparam logic [LO_W-1:0] LMIN = LO_W'(RST_MIN);
  localparam logic [LO_W-1:0] LMAX = LO_W'(RST_MAX);

  logic [LO_W-1:0] lo_q, lo_d;
  logic            lo_en;

  always_comb begin
    sleep     = (lo_q > LMAX);
    rst_pulse = en_pin && (lo_q >= LMIN) && (lo_q <= LMAX);
    lo_en     = 1'b1;
    if (en_pin) begin
      lo_d  = '0;
      lo_en = (lo_q != '0);
    end else if (lo_q == SAT) begin
      lo_d  = lo_q;
      lo_en = 1'b0;
    end else begin
      lo_d = lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end
endmodule

// File: rtl/gdm_fault_ctl.sv
module gdm_fault_ctl #(
  parameter int N_GATE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GATE-1:0] tmo,
  input  logic              det_dis,
  input  logic              clr_wr,
  input  logic              rst_pulse,
  input  logic              sleep,
  input  logic [N_GATE-1:0] sense_gate,
  input  logic [N_GATE-1:0] eff_cmd,
  output logic              fault_lat,
  output logic              gdf_lat,
  output logic [N_GATE-1:0] st_gate,
  output logic              clr_pend
);
  logic              fault_q, fault_d, gdf_q, gdf_d, clr_q;
  logic [N_GATE-1:0] st_q, st_d, tmo_v;
  logic              clr_go, st_en;

  always_comb begin
    tmo_v   = det_dis ? '0 : tmo;
    clr_go  = (clr_q || rst_pulse) && (sense_gate == eff_cmd);
    fault_d = fault_q;
    gdf_d   = gdf_q;
    st_d    = st_q;
    st_en   = 1'b0;
    if (sleep) begin
      fault_d = 1'b0;
      gdf_d   = 1'b0;
      st_d    = '0;
      st_en   = 1'b1;
    end else if (|tmo_v) begin
      fault_d = 1'b1;
      gdf_d   = 1'b1;
      st_d    = st_q | tmo_v;
      st_en   = 1'b1;
    end else if (clr_go) begin
      fault_d = 1'b0;
      gdf_d   = 1'b0;
      st_d    = '0;
      st_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      gdf_q   <= 1'b0;
      st_q    <= '0;
    end else if (st_en) begin
      fault_q <= fault_d;
      gdf_q   <= gdf_d;
      st_q    <= st_d;
    end
  end

  assign fault_lat = fault_q;
  assign gdf_lat   = gdf_q;
  assign st_gate   = st_q;
  assign clr_pend  = clr_q;
endmodule

// File: rtl/gdrv_timeout_mon.sv
module gdrv_timeout_mon #(
  parameter int N_GATE  = gdm_pkg::GATE_COUNT,
  parameter int WIN_W   = 8,
  parameter int RST_MIN = 4,
  parameter int RST_MAX = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_GATE-1:0] cmd_gate,
  input  logic [N_GATE-1:0] sense_gate,
  input  logic [WIN_W-1:0]  win_len,
  input  logic              det_dis,
  input  logic              clr_wr,
  input  logic              en_pin,
  output logic [N_GATE-1:0] drv_out,
  output logic              fault_n,
  output logic              st_fault,
  output logic              st_gdf,
  output logic [N_GATE-1:0] st_gate
);
  logic              fault_lat, gdf_lat, sleep_w, rst_pulse_w, clr_pend_w, kill;
  logic [N_GATE-1:0] eff_cmd, tmo_w;

  assign kill    = fault_lat | sleep_w;
  assign eff_cmd = kill ? '0 : cmd_gate;

  for (genvar g = 0; g < N_GATE; g++) begin : g_tmr
    gdm_gate_timer #(.WIN_W(WIN_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .eff_cmd (eff_cmd[g]),
      .sense   (sense_gate[g]),
      .win_len (win_len),
      .hold    (kill),
      .tmo     (tmo_w[g])
    );
  end

  gdm_en_filter #(.RST_MIN(RST_MIN), .RST_MAX(RST_MAX)) u_enf (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_pin    (en_pin),
    .rst_pulse (rst_pulse_w),
    .sleep     (sleep_w)
  );

  gdm_fault_ctl #(.N_GATE(N_GATE)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmo        (tmo_w),
    .det_dis    (det_dis),
    .clr_wr     (clr_wr),
    .rst_pulse  (rst_pulse_w),
    .sleep      (sleep_w),
    .sense_gate (sense_gate),
    .eff_cmd    (eff_cmd),
    .fault_lat  (fault_lat),
    .gdf_lat    (gdf_lat),
    .st_gate    (st_gate),
    .clr_pend   (clr_pend_w)
  );

  assign drv_out  = eff_cmd;
  assign fault_n  = ~fault_lat;
  assign st_fault = fault_lat;
  assign st_gdf   = gdf_lat;
endmodule

// File: rtl/gdm_checker.sv
module gdm_checker #(
  parameter int N_GATE = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det_dis,
  input logic [N_GATE-1:0] sense_gate,
  input logic [N_GATE-1:0] drv_out,
  input logic              fault_n,
  input logic              st_fault,
  input logic              st_gdf,
  input logic [N_GATE-1:0] st_gate,
  input logic              sleep,
  input logic              rst_pulse,
  input logic              clr_pend
);
  AST_OFF_WHEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> drv_out == '0); // R2

  AST_PIN_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_gdf) |-> (!fault_n && st_fault && st_gate != '0)); // R3

  AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr_pend && !rst_pulse && !sleep) |=> (!fault_n && $stable(st_gate))); // R10

  AST_CLEAR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_n) && !$past(sleep)) |-> $past(sense_gate) == '0); // R5

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> drv_out == '0); // R8

  AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (st_gate == '0 && fault_n)); // R8

  AST_DIS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (det_dis && fault_n) |=> fault_n); // R9
endmodule

bind gdrv_timeout_mon gdm_checker #(.N_GATE(N_GATE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .det_dis    (det_dis),
  .sense_gate (sense_gate),
  .drv_out    (drv_out),
  .fault_n    (fault_n),
  .st_fault   (st_fault),
  .st_gdf     (st_gdf),
  .st_gate    (st_gate),
  .sleep      (sleep_w),
  .rst_pulse  (rst_pulse_w),
  .clr_pend   (clr_pend_w)
);

// File: tb/sim_gdrv_timeout_mon.sv
`timescale 1ns/1ps
module sim_gdrv_timeout_mon;
  localparam int WIN  = 5;
  localparam int RMIN = 4;
  localparam int RMAX = 16;

  logic       clk, rst_n;
  logic [5:0] cmd_gate, sense_gate;
  logic [7:0] win_len;
  logic       det_dis, clr_wr, en_pin;
  logic [5:0] drv_out, st_gate;
  logic       fault_n, st_fault, st_gdf;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  gdrv_timeout_mon #(.N_GATE(6), .WIN_W(8), .RST_MIN(RMIN), .RST_MAX(RMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_gate(cmd_gate), .sense_gate(sense_gate),
    .win_len(win_len), .det_dis(det_dis), .clr_wr(clr_wr), .en_pin(en_pin),
    .drv_out(drv_out), .fault_n(fault_n), .st_fault(st_fault), .st_gdf(st_gdf),
    .st_gate(st_gate)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic make_fault(input logic [5:0] mask);
    cmd_gate = mask; sense_gate = '0;
    tick(WIN + 2);
    cmd_gate = '0;
    tick(1);
  endtask

  task automatic t_reset;
    chk("R3 reset fault_n", fault_n, 1);
    chk("R4 reset st_gate", st_gate, 0);
    chk("R2 reset drv_out", drv_out, 0);
  endtask

  task automatic t_follow;
    cmd_gate = 6'b101010; tick(2);
    sense_gate = 6'b101010; tick(WIN + 6);
    chk("R2 follow drv_out", drv_out, 6'b101010);
    chk("R1 follow no fault", fault_n, 1);
    cmd_gate = '0; tick(1);
    sense_gate = '0; tick(WIN + 6);
    chk("R1 fall no fault", fault_n, 1);
  endtask

  task automatic t_last_match;
    cmd_gate = 6'b000001; tick(WIN + 1);
    sense_gate = 6'b000001; tick(3);
    chk("R1 match in last cycle", fault_n, 1);
    cmd_gate = '0; sense_gate = '0; tick(WIN + 3);
  endtask

  task automatic t_timeout;
    cmd_gate = 6'b000100; sense_gate = '0;
    tick(WIN + 1);
    chk("R1 not yet faulted", fault_n, 1);
    tick(1);
    chk("R1 fault at deadline", fault_n, 0);
    chk("R4 HB status bit", st_gate, 6'b000100);
    chk("R3 st_fault", st_fault, 1);
    chk("R3 st_gdf", st_gdf, 1);
    chk("R2 outputs killed", drv_out, 0);
  endtask

  task automatic t_clear_blocked;
    cmd_gate = 6'b111111; tick(2);
    cmd_gate = 6'b010101; tick(WIN + 4);
    chk("R10 no new status bits", st_gate, 6'b000100);
    chk("R2 still killed", drv_out, 0);
    sense_gate = 6'b010000; cmd_gate = '0; clr_wr = 1'b1; tick(1);
    clr_wr = 1'b0; tick(3);
    chk("R5 clear ignored fault_n", fault_n, 0);
    chk("R5 clear ignored st_gate", st_gate, 6'b000100);
  endtask

  task automatic t_clear_strobe;
    sense_gate = '0; clr_wr = 1'b1; tick(1);
    clr_wr = 1'b0;
    chk("R6 one edge after strobe", fault_n, 0);
    tick(1);
    chk("R6 released", fault_n, 1);
    chk("R6 status cleared", st_gate, 0);
    chk("R3 st_fault cleared", st_fault, 0);
  endtask

  task automatic t_en_clear;
    make_fault(6'b100001);
    chk("R4 HA and LC bits", st_gate, 6'b100001);
    en_pin = 1'b0; tick(2);
    en_pin = 1'b1; tick(2);
    chk("R7 short pulse ignored", fault_n, 0);
    en_pin = 1'b0; tick(6);
    en_pin = 1'b1; tick(1);
    chk("R7 pulse clear", fault_n, 1);
    chk("R7 pulse clears status", st_gate, 0);
    make_fault(6'b001000);
    tick(3);
    chk("R6 clear bit self-cleared", fault_n, 0);
    en_pin = 1'b0; tick(RMIN);
    en_pin = 1'b1; tick(1);
    chk("R7 minimum width clear", fault_n, 1);
  endtask

  task automatic t_sleep;
    cmd_gate = 6'b001100; sense_gate = 6'b001100; tick(4);
    en_pin = 1'b0; tick(RMAX);
    chk("R8 awake at max width", drv_out, 6'b001100);
    tick(1);
    chk("R8 asleep outputs off", drv_out, 0);
    en_pin = 1'b1; tick(WIN + 4);
    chk("R8 wake outputs follow", drv_out, 6'b001100);
    chk("R8 wake no fault", fault_n, 1);
    make_fault(6'b000010);
    en_pin = 1'b0; tick(20);
    chk("R8 sleep releases pin", fault_n, 1);
    chk("R8 sleep clears status", st_gate, 0);
    en_pin = 1'b1; tick(2);
  endtask

  task automatic t_disable;
    det_dis = 1'b1; cmd_gate = 6'b110000; sense_gate = '0;
    tick(WIN + 6);
    chk("R9 disabled no fault", fault_n, 1);
    chk("R9 disabled no status", st_gate, 0);
    chk("R9 outputs follow", drv_out, 6'b110000);
    cmd_gate = '0; tick(WIN + 4);
    det_dis = 1'b0; tick(2);
    chk("R9 no late fault", fault_n, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_gate = '0; sense_gate = '0; win_len = 8'(WIN);
    det_dis = 1'b0; clr_wr = 1'b0; en_pin = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_follow();
    t_last_match();
    t_timeout();
    t_clear_blocked();
    t_clear_strobe();
    t_en_clear();
    t_sleep();
    t_disable();
    finish_run();
  end
endmodule